// File: doc/BRIEF.md
# Forward Detector Coincidence Trigger

This block builds the trigger for a set of forward spectrometer counters. Its inputs are a bunch-crossing marker and discriminated hit pulses from eight spectrometer counters and two dipole counters. Each rising edge of the marker opens an early window. A copy of that window, delayed by a fixed number of clock cycles, forms the in-time window. Every counter hit that falls inside one of the windows is classed as early or in-time, and the classified hit is stretched to a fixed length. After that, each arm combines its two counters: the early requirement is their OR and the in-time requirement is their AND.

The early arm terms are delayed so that they line up with the in-time terms of the diagonally opposite arm. This alignment produces four halo coincidences. Two elastic coincidences come from in-time hits on both diagonal sides. The minimum-bias term is the OR of all ten in-time counters and passes through a prescaler whose divisor can be written. The pedestal strobe is a delayed copy of the in-time window and passes through three prescalers in cascade. The eight resulting trigger bits go out in a fixed order, together with their OR as the master trigger. While the readout's busy input is high, no new early window opens, so every trigger is suppressed.

Top module: `fwd_coinc_trigger`

## Requirements
- R1: A rising edge of `xing_i` seen while `busy_i` is low opens an early window lasting `EW_LEN` cycles. A spectrometer hit present in any of the first `EW_LEN` cycles after that edge is classed early, including the last of those cycles.
- R2: The in-time window is the early window delayed by `IT_DLY` cycles and has the same length. A hit at offset `IT_DLY`+k is classed in-time for k from 0 to `EW_LEN`-1.
- R3: A hit outside both windows produces no trigger. This covers an early hit at offset `EW_LEN` and an in-time hit at offset `IT_DLY`+`EW_LEN`.
- R4: Each classified hit is stretched to `STRETCH` cycles. An early hit at offset a and an in-time hit at offset `IT_DLY`+b coincide when b-a < `STRETCH` and do not coincide when b-a = `STRETCH`.
- R5: The `hit_i` bits map as follows: 0 N1U, 1 N1D, 2 N2U, 3 N2D, 4 F1U, 5 F1D, 6 F2U, 7 F2D, 8 and 9 the dipole counters. The arms are NU={0,2}, ND={1,3}, FU={4,6} and FD={5,7}. An arm's early term is the OR of its two counters; its in-time term is their AND.
- R6: The halo bits are: `trig_o[0]` = early NU with in-time FD; `trig_o[1]` = early ND with in-time FU; `trig_o[2]` = early FU with in-time ND; `trig_o[3]` = early FD with in-time NU.
- R7: The elastic bits are: `trig_o[4]` = in-time NU with in-time FD; `trig_o[5]` = in-time ND with in-time FU.
- R8: `trig_o[6]` pulses for one cycle on every Nth rising edge of the OR of the ten stretched in-time hits, where N is the minimum-bias divisor.
- R9: The divisor resets to `MB_DIV_RST`. A write through `mb_div_we_i` takes effect only while `busy_i` is high, and an accepted write clears the minimum-bias count. A write while `busy_i` is low is ignored.
- R10: The pedestal strobe is the in-time window delayed by a further `PED_DLY` cycles. `trig_o[7]` pulses for one cycle once every `PED_DIV_A`*`PED_DIV_B`*`PED_DIV_C` unblocked crossings.
- R11: `master_o` is high exactly when at least one bit of `trig_o` is high.
- R12: A crossing whose marker edge arrives while `busy_i` is high opens no window. It produces no trigger bit, no master trigger, and no pedestal or minimum-bias count.
- R13: During and right after reset, `trig_o` and `master_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_i | input | 1 | Bunch-crossing marker; its rising edge starts a crossing |
| busy_i | input | 1 | Readout busy; blocks new windows and enables divisor writes |
| hit_i | input | 10 | Discriminated counter hits, bit map in R5 |
| mb_div_i | input | DIV_W | Minimum-bias prescale divisor |
| mb_div_we_i | input | 1 | Divisor write strobe |
| trig_o | output | 8 | Trigger bits: halo 0-3, elastic 4-5, minimum bias 6, pedestal 7 |
| master_o | output | 1 | Master trigger, the OR of the trigger bits |

## Verification
The hardest event to reach from the ports is the terminal count of the pedestal cascade, which normally needs close to ten million crossings. The bench gives the three stage divisors small values as parameters. It then runs enough empty crossings to reach the product of those divisors, and it follows the expected count crossing by crossing, leaving out blocked crossings. The divisor-write gate is also hard to see directly. To expose it, the bench follows an accepted write with an ignored one and then checks that the minimum-bias bit fires on the third in-time edge and not earlier.

// File: rtl/fwd_coinc_trigger.sv
module fwd_coinc_trigger #(
  parameter int EW_LEN     = 12,
  parameter int IT_DLY     = 36,
  parameter int STRETCH    = 10,
  parameter int PED_DLY    = 20,
  parameter int DIV_W      = 12,
  parameter int MB_DIV_RST = 1000,
  parameter int PED_DIV_A  = 999,
  parameter int PED_DIV_B  = 999,
  parameter int PED_DIV_C  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xing_i,
  input  logic             busy_i,
  input  logic [9:0]       hit_i,
  input  logic [DIV_W-1:0] mb_div_i,
  input  logic             mb_div_we_i,
  output logic [7:0]       trig_o,
  output logic             master_o
);
  localparam int EW_CW  = $clog2(EW_LEN + 1);
  localparam int ST_CW  = $clog2(STRETCH + 1);
  localparam int SR_LEN = IT_DLY + PED_DLY;

  logic             xing_q;
  logic [EW_CW-1:0] ew_cnt;
  logic             ew, iw, pw, pw_q;
  logic [SR_LEN-1:0] win_sr;
  logic [7:0]       e_str;
  logic [9:0]       i_str;
  logic [3:0]       eo, eo_d, ia;
  logic             mb_or, mb_or_q;
  logic [DIV_W-1:0] mb_div_q;
  logic             div_wr;
  logic [3:0]       pc_tick;
  logic [5:0]       phys;
  logic [7:0]       bits;

  wire start = xing_i & ~xing_q & ~busy_i;
  assign div_wr = mb_div_we_i & busy_i;
  assign ew = ew_cnt != '0;
  assign iw = win_sr[IT_DLY-1];
  assign pw = win_sr[SR_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xing_q   <= 1'b0;
      ew_cnt   <= '0;
      win_sr   <= '0;
      pw_q     <= 1'b0;
      mb_or_q  <= 1'b0;
      mb_div_q <= DIV_W'(MB_DIV_RST);
      trig_o   <= '0;
      master_o <= 1'b0;
    end else begin
      xing_q  <= xing_i;
      pw_q    <= pw;
      mb_or_q <= mb_or;
      win_sr  <= {win_sr[SR_LEN-2:0], ew};
      if (start) ew_cnt <= EW_CW'(EW_LEN);
      else if (ew) ew_cnt <= ew_cnt - 1'b1;
      if (div_wr) mb_div_q <= mb_div_i;
      trig_o   <= bits;
      master_o <= |bits;
    end
  end

  for (genvar c = 0; c < 8; c++) begin : g_early
    logic [ST_CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (hit_i[c] & ew) cnt <= ST_CW'(STRETCH);
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
    assign e_str[c] = cnt != '0;
  end

  for (genvar c = 0; c < 10; c++) begin : g_intime
    logic [ST_CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (hit_i[c] & iw) cnt <= ST_CW'(STRETCH);
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
    assign i_str[c] = cnt != '0;
  end

  // arm index: 0 NU, 1 ND, 2 FU, 3 FD; arm a uses counters base, base+2
  for (genvar a = 0; a < 4; a++) begin : g_arm
    localparam int B = (a < 2) ? a : a + 2;
    logic [IT_DLY-1:0] sr;
    assign eo[a] = e_str[B] | e_str[B+2];
    assign ia[a] = i_str[B] & i_str[B+2];
    always_ff @(posedge clk) begin
      if (!rst_n) sr <= '0;
      else sr <= {sr[IT_DLY-2:0], eo[a]};
    end
    assign eo_d[a] = sr[IT_DLY-1];
  end

  assign mb_or = |i_str;

  assign phys = {ia[1] & ia[2], ia[0] & ia[3],
                 eo_d[3] & ia[0], eo_d[2] & ia[1],
                 eo_d[1] & ia[2], eo_d[0] & ia[3]};
  assign bits = {pc_tick[3], pc_tick[0], phys};

  // stage 0: minimum bias; stages 1..3: pedestal cascade
  for (genvar g = 0; g < 4; g++) begin : g_pre
    logic [DIV_W-1:0] cnt, div;
    logic             tick, ev;
    if (g == 0) begin : g_s0
      assign div = mb_div_q;
      assign ev  = mb_or & ~mb_or_q;
    end else if (g == 1) begin : g_s1
      assign div = DIV_W'(PED_DIV_A);
      assign ev  = pw & ~pw_q;
    end else begin : g_sn
      assign div = DIV_W'((g == 2) ? PED_DIV_B : PED_DIV_C);
      assign ev  = pc_tick[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else begin
        tick <= 1'b0;
        if (g == 0 && div_wr) cnt <= '0;
        else if (ev) begin
          if (cnt + DIV_W'(1) >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
          end else cnt <= cnt + DIV_W'(1);
        end
      end
    end
    assign pc_tick[g] = tick;
  end
endmodule

module fwd_coinc_trigger_chk #(
  parameter int EW_CW  = 4,
  parameter int EW_LEN = 12,
  parameter int DIV_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xing_i,
  input logic             xing_q,
  input logic             busy_i,
  input logic [EW_CW-1:0] ew_cnt,
  input logic [DIV_W-1:0] mb_div_q,
  input logic [7:0]       trig_o,
  input logic             master_o
);
  AST_MASTER_MATCHES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    master_o == (|trig_o)); // R11
  AST_BUSY_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && xing_i && !xing_q) |=> (ew_cnt != EW_CW'(EW_LEN))); // R12
  AST_DIV_HELD_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> $stable(mb_div_q)); // R9
  AST_MB_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o[6] |=> !trig_o[6]); // R8
  AST_PED_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o[7] |=> !trig_o[7]); // R10
endmodule

bind fwd_coinc_trigger fwd_coinc_trigger_chk #(
  .EW_CW(EW_CW), .EW_LEN(EW_LEN), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .xing_q(xing_q), .busy_i(busy_i),
  .ew_cnt(ew_cnt), .mb_div_q(mb_div_q), .trig_o(trig_o), .master_o(master_o)
);

// File: tb/test_fwd_coinc_trigger.sv
module test_fwd_coinc_trigger;
  localparam int D = 36;
  localparam int PED_PERIOD = 3 * 4 * 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xing_i = 1'b0;
  logic        busy_i = 1'b0;
  logic [9:0]  hit_i = '0;
  logic [11:0] mb_div_i = '0;
  logic        mb_div_we_i = 1'b0;
  logic [7:0]  trig_o;
  logic        master_o;

  int total = 0, bad = 0;
  int mb_div = 1000, mb_cnt = 0, xcnt = 0;

  always #4 clk = ~clk;

  fwd_coinc_trigger #(.PED_DIV_A(3), .PED_DIV_B(4), .PED_DIV_C(5)) i_fwd_coinc_trigger (
    .clk(clk), .rst_n(rst_n), .xing_i(xing_i), .busy_i(busy_i), .hit_i(hit_i),
    .mb_div_i(mb_div_i), .mb_div_we_i(mb_div_we_i), .trig_o(trig_o), .master_o(master_o));

  // {early[7:0], intime[9:0], early offset, intime offset, expected trig[5:0]}
  localparam logic [31:0] VEC [16] = '{
    {8'h01, 10'h0A0, 4'd2,  4'd2,  6'h01},  // R6 halo 0 via N1U
    {8'h04, 10'h0A0, 4'd2,  4'd2,  6'h01},  // R5 early OR via N2U
    {8'h02, 10'h050, 4'd2,  4'd2,  6'h02},  // R6 halo 1
    {8'h10, 10'h00A, 4'd2,  4'd2,  6'h04},  // R6 halo 2
    {8'h80, 10'h005, 4'd2,  4'd2,  6'h08},  // R6 halo 3
    {8'h00, 10'h0A5, 4'd2,  4'd2,  6'h10},  // R7 elastic 0
    {8'h00, 10'h05A, 4'd2,  4'd2,  6'h20},  // R7 elastic 1
    {8'h01, 10'h020, 4'd2,  4'd2,  6'h00},  // R5 in-time needs both counters
    {8'h01, 10'h0A5, 4'd2,  4'd2,  6'h11},  // R6 R7 together
    {8'hFF, 10'h0FF, 4'd2,  4'd2,  6'h3F},  // R6 R7 all six
    {8'h01, 10'h0A0, 4'd0,  4'd9,  6'h01},  // R4 overlap inside stretch
    {8'h01, 10'h0A0, 4'd0,  4'd10, 6'h00},  // R4 gap equals stretch
    {8'h01, 10'h0A0, 4'd12, 4'd2,  6'h00},  // R3 early hit after window
    {8'h01, 10'h0A0, 4'd11, 4'd11, 6'h01},  // R1 R2 last window cycle
    {8'h00, 10'h300, 4'd2,  4'd2,  6'h00},  // R8 dipoles only
    {8'h01, 10'h0A0, 4'd2,  4'd12, 6'h00}   // R2 R3 in-time hit after window
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_event(input logic [7:0] e, input logic [9:0] i, input int eoff,
                           input int ioff, input logic [5:0] exp6, input string tag);
    logic [7:0] seen = '0;
    logic       mseen = 1'b0;
    logic       mb_fire = 1'b0, ped_fire = 1'b0;
    logic [5:0] exp_phys;
    exp_phys = busy_i ? 6'h00 : exp6;
    if (!busy_i) begin
      xcnt++;
      ped_fire = (xcnt % PED_PERIOD) == 0;
      if (i != 0 && ioff <= 11) begin
        mb_cnt++;
        if (mb_cnt >= mb_div) begin
          mb_cnt = 0;
          mb_fire = 1'b1;
        end
      end
    end
    @(negedge clk) xing_i = 1'b1;
    @(negedge clk) xing_i = 1'b0;
    for (int k = 0; k < 110; k++) begin
      if (k != 0) @(negedge clk);
      seen |= trig_o;
      mseen |= master_o;
      hit_i = ((k == eoff) ? {2'b00, e} : 10'h000) | ((k == D + ioff) ? i : 10'h000);
    end
    @(negedge clk) hit_i = '0;
    check(seen[5:0] == exp_phys, tag, seen[5:0], exp_phys);
    check(seen[6] == mb_fire, "R8 minimum-bias prescale", seen[6], mb_fire);
    check(seen[7] == ped_fire, "R10 pedestal cascade", seen[7], ped_fire);
    check(mseen == (|{ped_fire, mb_fire, exp_phys}), "R11 master OR", mseen,
          |{ped_fire, mb_fire, exp_phys});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(trig_o == 8'h00, "R13 reset trig", trig_o, 0);
    check(master_o == 1'b0, "R13 reset master", master_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig_o == 8'h00 && master_o == 1'b0, "R13 after reset", {master_o, trig_o}, 0);

    for (int r = 0; r < 16; r++) begin
      run_event(VEC[r][31:24], VEC[r][23:14], int'(VEC[r][13:10]), int'(VEC[r][9:6]),
                VEC[r][5:0], $sformatf("R1 R2 R3 R4 R5 R6 R7 row %0d", r));
    end

    // R12 busy blocks a full halo plus elastic crossing
    @(negedge clk) busy_i = 1'b1;
    run_event(8'h01, 10'h0A5, 2, 2, 6'h11, "R12 busy blocks triggers");

    // R9 accepted write while busy, ignored write while running
    @(negedge clk) begin mb_div_i = 12'd3; mb_div_we_i = 1'b1; end
    @(negedge clk) begin mb_div_we_i = 1'b0; busy_i = 1'b0; end
    @(negedge clk) begin mb_div_i = 12'd1; mb_div_we_i = 1'b1; end
    @(negedge clk) mb_div_we_i = 1'b0;
    mb_div = 3;
    mb_cnt = 0;
    for (int n = 0; n < 3; n++) run_event(8'h00, 10'h300, 2, 2, 6'h00, "R9 divisor write gate");

    // R10 run empty crossings up to the cascade terminal count
    while (xcnt < PED_PERIOD) run_event(8'h00, 10'h000, 2, 2, 6'h00, "R10 filler crossing");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule